// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver with Majority Voting

This block recovers bytes from an asynchronous serial line that carries frames of one low start bit, eight data bits and one high stop bit. It does not generate its own timing: a sample tick, one clock cycle wide and running at sixteen times the bit rate, comes from outside. For example, a 50 MHz clock divided down to 16 × 115200 Hz provides this tick. The line is first passed through a two-flop synchroniser. Each bit is then resolved by a two-of-three vote over the samples near its centre, so a single corrupted sample cannot change the received value.

A received byte appears on a parallel output together with a one-cycle valid strobe. If the stop bit resolves low, the block raises a one-cycle framing-error strobe instead. A busy flag covers the time from start detection to the end of the stop bit. A receive enable freezes the whole receiver. While the enable is low, ticks and line activity are ignored and all state is held, so a frame can be paused and then resumed.

Top module: `serial_vote_rx`

## Requirements
- R1: A synchronous active-high reset clears the busy flag, the valid strobe, the framing-error strobe and the received byte to zero.
- R2: While idle, a tick at which the synchronised line reads low after reading high on the previous enabled tick is sample 0 of a start bit. The busy flag is high in the cycle after that tick.
- R3: If at least two of samples 7, 8 and 9 of the start bit read high, the start is discarded at sample 15. The receiver returns to idle with neither strobe raised.
- R4: Every data and stop bit takes the value held by at least two of its samples 7, 8 and 9, counted from sample 0 at the bit boundary. A single deviating sample anywhere in a bit does not change the result.
- R5: Exactly eight data bits follow the start bit, and the first data bit received lands in bit 0 of the byte (least significant bit first).
- R6: When the stop bit resolves high, `rx_byte` takes the new value in the same cycle that `rx_valid` is high for exactly one cycle. `rx_byte` changes at no other time.
- R7: When the stop bit resolves low, `frame_err` is high for one cycle, `rx_valid` stays low and `rx_byte` keeps its previous value.
- R8: The receiver is idle again immediately after sample 15 of the stop bit. A start bit beginning on the very next tick is received.
- R9: While `rx_en` is low, ticks and the line are ignored: busy, counters and shift state hold, and no strobe is raised. A frame paused this way completes correctly when the enable returns.
- R10: Busy stays high from start detection until the end of the stop bit (or the end of a discarded start bit), and changes only on an enabled tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; low freezes the receiver |
| sample_tick | input | 1 | One-cycle pulse at 16× the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_byte | output | DATA_W | Last correctly framed byte |
| rx_valid | output | 1 | One-cycle strobe, new byte on `rx_byte` |
| rx_busy | output | 1 | Frame in progress |
| frame_err | output | 1 | One-cycle strobe, stop bit read low |

## Verification
The bench builds the block with its default parameters: eight data bits, 16× oversampling, a three-sample vote window starting at sample 7, and a two-stage synchroniser. It drives a tick every 4 clocks rather than the roughly 27 that a real 115200 baud link would need. Each tick then aligns exactly with one bench-driven sample slot, which lets single-sample glitches be placed on chosen vote positions. The shorter tick period also lets dozens of back-to-back frames, a paused frame, a rejected start and a framing error run in a short simulation.

// File: rtl/serial_vote_rx_pkg.sv
package serial_vote_rx_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

endpackage

// File: rtl/svr_sync.sv
module svr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain_q;

   // Reset to the idle (high) level so no false start follows reset.
   always_ff @(posedge clk) begin
      if (rst) chain_q <= '1;
      else     chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/svr_bit_timer.sv
module svr_bit_timer #(
   parameter int OSR     = 16,
   parameter int VOTE_LO = 7,
   parameter int VOTE_N  = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,   // start edge seen: this tick was sample 0
   input  logic advance,   // enabled tick while a frame is active
   input  logic line,
   output logic bit_end,
   output logic bit_val
);
   localparam int CNT_W = (OSR > 1) ? $clog2(OSR) : 1;
   localparam logic [CNT_W-1:0] LAST   = CNT_W'(OSR - 1);
   localparam logic [CNT_W-1:0] WIN_LO = CNT_W'(VOTE_LO);
   localparam logic [CNT_W-1:0] WIN_HI = CNT_W'(VOTE_LO + VOTE_N - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             in_win;

   assign in_win  = (cnt_q >= WIN_LO) && (cnt_q <= WIN_HI);
   assign bit_end = advance && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (rst)          cnt_q <= '0;
      else if (restart) cnt_q <= CNT_W'(1);
      else if (advance) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   end

   generate
      if (VOTE_N == 1) begin : g_single
         logic smp_q;
         always_ff @(posedge clk) begin
            if (rst)                    smp_q <= 1'b1;
            else if (advance && in_win) smp_q <= line;
         end
         assign bit_val = smp_q;
      end else begin : g_major
         localparam int ONES_W = $clog2(VOTE_N + 1);
         localparam logic [ONES_W-1:0] HALF = ONES_W'(VOTE_N / 2);
         logic [ONES_W-1:0] ones_q;
         always_ff @(posedge clk) begin
            if (rst || restart) ones_q <= '0;
            else if (advance) begin
               if (in_win)              ones_q <= ones_q + ONES_W'(line);
               else if (cnt_q == LAST)  ones_q <= '0;
            end
         end
         assign bit_val = (ones_q > HALF);
      end
   endgenerate
endmodule

// File: rtl/svr_frame_ctrl.sv
module svr_frame_ctrl
   import serial_vote_rx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,      // enabled tick
   input  logic              line,
   input  logic              bit_end,
   input  logic              bit_val,
   output logic              start_seen,
   output logic              active,
   output logic [DATA_W-1:0] byte_q,
   output logic              valid_q,
   output logic              ferr_q
);
   localparam int BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [BC_W-1:0] BC_LAST = BC_W'(DATA_W - 1);

   rx_state_e         state_q;
   logic              prev_q;
   logic [BC_W-1:0]   bcnt_q;
   logic [DATA_W-1:0] shift_q;

   assign start_seen = step && (state_q == RX_IDLE) && prev_q && !line;
   assign active     = (state_q != RX_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= RX_IDLE;
         prev_q  <= 1'b1;
         bcnt_q  <= '0;
         shift_q <= '0;
         byte_q  <= '0;
         valid_q <= 1'b0;
         ferr_q  <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         ferr_q  <= 1'b0;
         if (step) begin
            prev_q <= line;
            unique case (state_q)
               RX_IDLE: begin
                  if (prev_q && !line) state_q <= RX_START;
               end
               RX_START: begin
                  if (bit_end) begin
                     bcnt_q  <= '0;
                     state_q <= bit_val ? RX_IDLE : RX_DATA;
                  end
               end
               RX_DATA: begin
                  if (bit_end) begin
                     shift_q <= {bit_val, shift_q[DATA_W-1:1]};
                     if (bcnt_q == BC_LAST) state_q <= RX_STOP;
                     else                   bcnt_q  <= bcnt_q + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (bit_end) begin
                     state_q <= RX_IDLE;
                     if (bit_val) begin
                        byte_q  <= shift_q;
                        valid_q <= 1'b1;
                     end else begin
                        ferr_q  <= 1'b1;
                     end
                  end
               end
               default: state_q <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/serial_vote_rx.sv
module serial_vote_rx #(
   parameter int DATA_W      = 8,
   parameter int OSR         = 16,
   parameter int VOTE_LO     = 7,
   parameter int VOTE_N      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rx_en,
   input  logic              sample_tick,
   input  logic              rx_line,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_valid,
   output logic              rx_busy,
   output logic              frame_err
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("serial_vote_rx: DATA_W must be at least 2");
      end
      if (OSR < 4) begin : g_bad_osr
         $error("serial_vote_rx: OSR must be at least 4");
      end
      if ((VOTE_N % 2) == 0 || VOTE_N < 1) begin : g_bad_vote
         $error("serial_vote_rx: VOTE_N must be odd and positive");
      end
      if (VOTE_LO < 1 || VOTE_LO + VOTE_N > OSR - 1) begin : g_bad_window
         $error("serial_vote_rx: vote window must lie inside samples 1..OSR-2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("serial_vote_rx: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic line_s;
   logic step;
   logic start_seen;
   logic active;
   logic bit_end;
   logic bit_val;

   assign step = rx_en && sample_tick;

   svr_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk  (clk),
      .rst  (rst),
      .din  (rx_line),
      .dout (line_s)
   );

   svr_bit_timer #(.OSR(OSR), .VOTE_LO(VOTE_LO), .VOTE_N(VOTE_N)) timer_i (
      .clk     (clk),
      .rst     (rst),
      .restart (start_seen),
      .advance (step && active),
      .line    (line_s),
      .bit_end (bit_end),
      .bit_val (bit_val)
   );

   svr_frame_ctrl #(.DATA_W(DATA_W)) ctrl_i (
      .clk        (clk),
      .rst        (rst),
      .step       (step),
      .line       (line_s),
      .bit_end    (bit_end),
      .bit_val    (bit_val),
      .start_seen (start_seen),
      .active     (active),
      .byte_q     (rx_byte),
      .valid_q    (rx_valid),
      .ferr_q     (frame_err)
   );

   assign rx_busy = active;
endmodule

// File: rtl/serial_vote_rx_chk.sv
module serial_vote_rx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              rx_en,
   input logic              sample_tick,
   input logic [DATA_W-1:0] rx_byte,
   input logic              rx_valid,
   input logic              rx_busy,
   input logic              frame_err
);
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      rx_valid |=> !rx_valid); // R6
   AST_BYTE_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (rst)
      !$stable(rx_byte) |-> rx_valid); // R6
   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      frame_err |=> !frame_err); // R7
   AST_ERR_EXCLUDES_VALID: assert property (@(posedge clk) disable iff (rst)
      !(rx_valid && frame_err)); // R7
   AST_IDLE_AT_STROBE: assert property (@(posedge clk) disable iff (rst)
      (rx_valid || frame_err) |-> !rx_busy); // R8
   AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (rst)
      !rx_en |=> ($stable(rx_busy) && !rx_valid && !frame_err)); // R9
   AST_BUSY_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (rst)
      !sample_tick |=> $stable(rx_busy)); // R10
endmodule

bind serial_vote_rx serial_vote_rx_chk #(.DATA_W(DATA_W)) chk_i (
   .clk         (clk),
   .rst         (rst),
   .rx_en       (rx_en),
   .sample_tick (sample_tick),
   .rx_byte     (rx_byte),
   .rx_valid    (rx_valid),
   .rx_busy     (rx_busy),
   .frame_err   (frame_err)
);

// File: tb/serial_vote_rx_tb.sv
module serial_vote_rx_tb_top;
   localparam int TICK_DIV = 4;
   localparam int OSR      = 16;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rx_en = 1'b1;
   logic       sample_tick = 1'b0;
   logic       rx_line = 1'b1;
   logic [7:0] rx_byte;
   logic       rx_valid;
   logic       rx_busy;
   logic       frame_err;

   int n_checks = 0;
   int n_fail   = 0;
   int n_got    = 0;
   int n_ferr   = 0;
   int n_double = 0;
   bit done     = 1'b0;
   logic [7:0] got [0:63];

   always #10 clk = ~clk;

   serial_vote_rx #(.DATA_W(8), .OSR(OSR), .VOTE_LO(7), .VOTE_N(3), .SYNC_STAGES(2)) dut_i (
      .clk (clk), .rst (rst), .rx_en (rx_en), .sample_tick (sample_tick),
      .rx_line (rx_line), .rx_byte (rx_byte), .rx_valid (rx_valid),
      .rx_busy (rx_busy), .frame_err (frame_err)
   );

   // tick generator
   initial begin
      int div = 0;
      forever begin
         @(negedge clk);
         div = (div == TICK_DIV - 1) ? 0 : div + 1;
         sample_tick = (div == 0);
      end
   end

   // strobe monitor
   initial begin
      bit pv = 1'b0;
      forever begin
         @(negedge clk);
         if (rx_valid) begin
            if (n_got < 64) got[n_got] = rx_byte;
            n_got++;
            if (pv) n_double++;
         end
         if (frame_err) n_ferr++;
         pv = rx_valid;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic one_tick();
      do @(posedge clk); while (sample_tick !== 1'b1);
      @(negedge clk);
   endtask

   // model: 2-of-3 vote over slots 7..9 of one bit with optional glitch slot
   function automatic logic vote_bit(input logic v, input int gslot);
      int ones = 0;
      for (int s = 7; s <= 9; s++) ones += ((s == gslot) ? !v : v);
      return (ones >= 2);
   endfunction

   function automatic logic [7:0] model_byte(input logic [7:0] d, input int gbit, input int gslot);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = vote_bit(d[i], (gbit == i + 1) ? gslot : -1);
      return r;
   endfunction

   // bit 0 = start, 1..8 = data LSB first, 9 = stop
   task automatic send_frame(input logic [7:0] d, input int gbit, input int gslot,
                             input logic stop_v, input int pbit, input int pslot,
                             input int plen);
      for (int b = 0; b < 10; b++) begin
         logic v;
         v = (b == 0) ? 1'b0 : (b == 9) ? stop_v : d[b-1];
         for (int s = 0; s < OSR; s++) begin
            rx_line = (b == gbit && s == gslot) ? !v : v;
            if (b == pbit && s == pslot) begin
               rx_en = 1'b0;
               repeat (plen) one_tick();
               chk(rx_busy == 1'b1, "R9 busy held while paused", rx_busy, 1);
               rx_en = 1'b1;
            end
            one_tick();
         end
      end
   endtask

   task automatic idle_bit();
      rx_line = 1'b1;
      repeat (OSR) one_tick();
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      int exp_got = 0;
      int exp_ferr = 0;
      int seed;
      logic [7:0] last;
      seed = $urandom(32'h5EED);
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk(rx_busy == 0 && rx_valid == 0 && frame_err == 0 && rx_byte == 0,
          "R1 reset state", {rx_busy, rx_valid, frame_err, rx_byte}, 0);
      rst = 1'b0;
      idle_bit();

      // R5: LSB first
      send_frame(8'hA3, -1, -1, 1'b1, -1, -1, 0);
      #1;
      exp_got++;
      chk(n_got == exp_got, "R6 one valid per frame", n_got, exp_got);
      chk(rx_byte == 8'hA3, "R5 LSB-first byte", rx_byte, 8'hA3);
      last = 8'hA3;

      // R4: glitch inside vote window
      send_frame(8'h5C, 4, 8, 1'b1, -1, -1, 0);
      #1;
      exp_got++;
      chk(rx_byte == model_byte(8'h5C, 4, 8), "R4 glitch outvoted", rx_byte, model_byte(8'h5C, 4, 8));
      last = rx_byte;

      // R2/R3: start glitch of 4 samples
      rx_line = 1'b0;
      one_tick();
      chk(rx_busy == 1'b1, "R2 busy after start edge", rx_busy, 1);
      for (int s = 1; s < OSR; s++) begin
         rx_line = (s < 4) ? 1'b0 : 1'b1;
         one_tick();
      end
      #1;
      chk(rx_busy == 1'b0, "R3 glitch start discarded", rx_busy, 0);
      chk(n_got == exp_got && n_ferr == exp_ferr, "R3 no strobe on glitch", n_got, exp_got);
      idle_bit();

      // R7: framing error
      send_frame(8'h3E, -1, -1, 1'b0, -1, -1, 0);
      #1;
      exp_ferr++;
      chk(n_ferr == exp_ferr, "R7 frame error strobe", n_ferr, exp_ferr);
      chk(n_got == exp_got, "R7 no valid on frame error", n_got, exp_got);
      chk(rx_byte == last, "R7 byte kept", rx_byte, last);
      idle_bit();

      // R9: whole frame while disabled
      rx_en = 1'b0;
      send_frame(8'hC4, -1, -1, 1'b1, -1, -1, 0);
      #1;
      chk(n_got == exp_got && rx_busy == 0, "R9 disabled frame ignored", n_got, exp_got);
      chk(rx_byte == last, "R9 byte untouched", rx_byte, last);
      rx_en = 1'b1;
      idle_bit();

      // R9: paused mid-frame
      send_frame(8'h96, -1, -1, 1'b1, 5, 3, 37);
      #1;
      exp_got++;
      chk(rx_byte == 8'h96, "R9 paused frame completes", rx_byte, 8'h96);
      chk(n_got == exp_got, "R9 one valid after pause", n_got, exp_got);

      // R8/R4: back-to-back random frames with random single glitches
      for (int k = 0; k < 24; k++) begin
         logic [7:0] d;
         logic [7:0] e;
         int gb;
         int gs;
         d  = 8'($urandom_range(0, 255));
         gb = $urandom_range(1, 9);
         gs = $urandom_range(0, 15);
         e  = model_byte(d, gb, gs);
         send_frame(d, gb, gs, 1'b1, -1, -1, 0);
         #1;
         exp_got++;
         chk(rx_byte == e, "R8 back-to-back byte (R4 vote)", rx_byte, e);
         chk(rx_busy == 1'b0, "R10 busy ends after stop", rx_busy, 0);
      end
      chk(n_got == exp_got, "R8 frame count", n_got, exp_got);
      chk(n_double == 0, "R6 valid single cycle", n_double, 0);
      chk(n_ferr == exp_ferr, "R7 no spurious frame error", n_ferr, exp_ferr);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule